// File: doc/BRIEF.md
# Packed Saturating Integer Adder

A 64-bit add/subtract datapath that splits its operands into independent lanes of equal width: eight 8-bit, four 16-bit, two 32-bit or one 64-bit lane. One operation code selects addition or subtraction for every lane in the same cycle. Carries never pass from one lane to the next.

A mode input chooses one of three behaviours when a lane overflows. The lane can wrap modulo its width. It can clamp to the signed range of the lane. It can clamp to the unsigned range of the lane. Clamping is available only on the narrow lanes (8 and 16 bits). For the wide lanes (32 and 64 bits) the block always wraps. The block is used as a media-style execution slice: the issue logic presents the operands with a valid strobe, and one cycle later the registered result comes out, together with per-byte flags that mark the lanes which were clamped.

Top module: `psat_add_unit`

## Requirements
- R1: While rst_ni is low, valid_o, res_o and sat_o are all zero.
- R2: valid_o equals valid_i of the previous clock edge. res_o and sat_o are loaded only on edges where valid_i is high, and hold their values otherwise.
- R3: Lane size is encoded in size_i as 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. Lane k occupies bits [k*n +: n]. With mode_i = 0 (wrap) each lane result is (a + b) mod 2^n, and no carry crosses a lane boundary.
- R4: op_i = 0 selects addition and op_i = 1 selects subtraction (a - b), computed per lane modulo 2^n in wrap mode.
- R5: With mode_i = 1 (signed saturation) and 8- or 16-bit lanes, each lane result is its exact signed sum or difference, clamped to the range -2^(n-1) to 2^(n-1)-1.
- R6: With mode_i = 2 (unsigned saturation) and 8- or 16-bit lanes, each lane result is the exact unsigned sum or difference, clamped to the range 0 to 2^n-1. A difference below zero yields 0.
- R7: Saturating modes with 32- or 64-bit lanes, and mode_i = 3 with any lane size, behave as wrap mode and never raise a flag.
- R8: sat_o bit j is high exactly when the lane containing byte j clamped its result. All bytes of one lane carry the same flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and controls are valid |
| op_i | input | 1 | 0 = add, 1 = subtract |
| size_i | input | 2 | Lane size: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| mode_i | input | 2 | 0 = wrap, 1 = signed saturate, 2 = unsigned saturate, 3 = wrap |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| res_o | output | 64 | Packed lane results |
| sat_o | output | 8 | Per-byte clamp flags |

## Verification
The hardest situation to reach is a clamp on the boundary itself: a sum or difference that lands exactly on a lane limit must pass through unchanged, while one more must clamp. A second case is a 16-bit lane whose low byte produces a carry but whose high byte decides the clamp. Random byte patterns seldom hit these cases. The bench therefore sweeps a dense stepped grid of byte values in every lane with different offsets per byte. It also replicates the lane-level extreme values (0, 1, signed maximum and minimum, unsigned maximum and one below it) across all lanes, for every size, mode and operation. A bench model built on plain integer arithmetic supplies the expected values.

// File: rtl/psat_pkg.sv
package psat_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NBYTES = DATA_W / BYTE_W;
  localparam int unsigned IDX_W  = $clog2(NBYTES);

  typedef enum logic [1:0] {SZ_B8, SZ_B16, SZ_B32, SZ_B64} lane_sz_e;
  typedef enum logic [1:0] {MD_WRAP, MD_SSAT, MD_USAT, MD_RSVD} sat_md_e;
  typedef enum logic {OP_ADD, OP_SUB} op_e;
endpackage

// File: rtl/psat_lane_decode.sv
module psat_lane_decode
  import psat_pkg::*;
(
  input  logic [1:0]        size_i,
  input  logic [1:0]        mode_i,
  output logic [IDX_W-1:0]  grp_m1_o,
  output logic [NBYTES-1:0] start_o,
  output logic [NBYTES-1:0] last_o,
  output logic              ssat_o,
  output logic              usat_o
);
  logic narrow;

  always_comb begin
    // bytes per lane minus one: 0,1,3,7
    grp_m1_o = IDX_W'((1 << size_i) - 1);
    for (int i = 0; i < NBYTES; i++) begin
      start_o[i] = (IDX_W'(i) & grp_m1_o) == '0;
      last_o[i]  = (IDX_W'(i) & grp_m1_o) == grp_m1_o;
    end
    narrow = (size_i == SZ_B8) || (size_i == SZ_B16);
    ssat_o = narrow && (mode_i == MD_SSAT);
    usat_o = narrow && (mode_i == MD_USAT);
  end
endmodule

// File: rtl/psat_carry_chain.sv
module psat_carry_chain
  import psat_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic [NBYTES-1:0] start_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [NBYTES-1:0] cout_o,
  output logic [NBYTES-1:0] sovf_o,
  output logic [NBYTES-1:0] amsb_o
);
  always_comb begin
    logic              c;
    logic [BYTE_W:0]   t;
    logic [BYTE_W-1:0] aa;
    logic [BYTE_W-1:0] bb;
    c = 1'b0;
    for (int i = 0; i < NBYTES; i++) begin
      aa = a_i[i*BYTE_W +: BYTE_W];
      bb = b_i[i*BYTE_W +: BYTE_W] ^ {BYTE_W{sub_i}};
      // chain restarts at each lane start; carry-in of 1 completes two's complement
      if (start_i[i]) c = sub_i;
      t = {1'b0, aa} + {1'b0, bb} + {{BYTE_W{1'b0}}, c};
      sum_o[i*BYTE_W +: BYTE_W] = t[BYTE_W-1:0];
      cout_o[i] = t[BYTE_W];
      sovf_o[i] = (aa[BYTE_W-1] == bb[BYTE_W-1]) && (t[BYTE_W-1] != aa[BYTE_W-1]);
      amsb_o[i] = aa[BYTE_W-1];
      c = t[BYTE_W];
    end
  end
endmodule

// File: rtl/psat_clamp.sv
module psat_clamp
  import psat_pkg::*;
(
  input  logic [DATA_W-1:0] sum_i,
  input  logic [NBYTES-1:0] cout_i,
  input  logic [NBYTES-1:0] sovf_i,
  input  logic [NBYTES-1:0] amsb_i,
  input  logic [NBYTES-1:0] last_i,
  input  logic [IDX_W-1:0]  grp_m1_i,
  input  logic              ssat_i,
  input  logic              usat_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic [NBYTES-1:0] sat_o
);
  logic [NBYTES-1:0] lane_hit;

  always_comb begin
    for (int j = 0; j < NBYTES; j++) begin
      lane_hit[j] = last_i[j] &
                    ((ssat_i & sovf_i[j]) | (usat_i & (sub_i ? ~cout_i[j] : cout_i[j])));
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    logic [IDX_W-1:0]  end_idx;
    logic              top, neg;
    logic [BYTE_W-1:0] cval;

    always_comb begin
      end_idx = IDX | grp_m1_i;
      top     = (IDX == end_idx);
      neg     = amsb_i[end_idx];
      if (ssat_i) begin
        // overflow direction follows the sign of the first operand
        if (top) cval = neg ? {1'b1, {(BYTE_W-1){1'b0}}} : {1'b0, {(BYTE_W-1){1'b1}}};
        else     cval = neg ? '0 : '1;
      end else begin
        cval = sub_i ? '0 : '1;
      end
      sat_o[i] = lane_hit[end_idx];
      res_o[i*BYTE_W +: BYTE_W] = sat_o[i] ? cval : sum_i[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/psat_add_unit.sv
module psat_add_unit
  import psat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              op_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic [NBYTES-1:0] sat_o
);
  logic [IDX_W-1:0]  grp_m1;
  logic [NBYTES-1:0] start, last, cout, sovf, amsb, sat_d;
  logic              ssat, usat, sub;
  logic [DATA_W-1:0] sum, res_d;

  assign sub = (op_i == OP_SUB);

  psat_lane_decode i_decode (
    .size_i  (size_i),
    .mode_i  (mode_i),
    .grp_m1_o(grp_m1),
    .start_o (start),
    .last_o  (last),
    .ssat_o  (ssat),
    .usat_o  (usat)
  );

  psat_carry_chain i_chain (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub),
    .start_i(start),
    .sum_o  (sum),
    .cout_o (cout),
    .sovf_o (sovf),
    .amsb_o (amsb)
  );

  psat_clamp i_clamp (
    .sum_i   (sum),
    .cout_i  (cout),
    .sovf_i  (sovf),
    .amsb_i  (amsb),
    .last_i  (last),
    .grp_m1_i(grp_m1),
    .ssat_i  (ssat),
    .usat_i  (usat),
    .sub_i   (sub),
    .res_o   (res_d),
    .sat_o   (sat_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      sat_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o <= res_d;
        sat_o <= sat_d;
      end
    end
  end

  a_r2_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(sat_o)));
  a_r3_lane0_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MD_WRAP && op_i == OP_ADD && size_i == SZ_B8)
    |=> res_o[7:0] == $past(a_i[7:0] + b_i[7:0]));
  a_r5_s16_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MD_SSAT && op_i == OP_ADD && size_i == SZ_B16 &&
     !a_i[15] && !b_i[15] && (({1'b0, a_i[15:0]} + {1'b0, b_i[15:0]}) >= 17'h08000))
    |=> (res_o[15:0] == 16'h7fff && sat_o[1:0] == 2'b11));
  a_r6_u8_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MD_USAT && op_i == OP_SUB && size_i == SZ_B8 && a_i[7:0] < b_i[7:0])
    |=> (res_o[7:0] == 8'h00 && sat_o[0]));
  a_r7_no_flag_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (size_i == SZ_B32 || size_i == SZ_B64 || mode_i == MD_WRAP || mode_i == MD_RSVD))
    |=> sat_o == '0);
  a_r8_flag_uniform16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == SZ_B16)
    |=> (sat_o[0] == sat_o[1] && sat_o[2] == sat_o[3] &&
         sat_o[4] == sat_o[5] && sat_o[6] == sat_o[7]));
endmodule

// File: tb/test_psat_add_unit.sv
module test_psat_add_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        op_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [1:0]  mode_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic        valid_o;
  logic [63:0] res_o;
  logic [7:0]  sat_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psat_add_unit i_psat_add_unit (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .size_i(size_i), .mode_i(mode_i), .a_i(a_i), .b_i(b_i),
    .valid_o(valid_o), .res_o(res_o), .sat_o(sat_o)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (size %0d mode %0d op %0d a %h b %h)",
               req, got, exp, size_i, mode_i, op_i, a_i, b_i);
    end
  endtask

  function automatic void ref_op(input logic [63:0] a, input logic [63:0] b,
                                 input int sz, input int md, input int op,
                                 output logic [63:0] r, output logic [7:0] s);
    int n, lanes, nb;
    bit sat_ok, cl;
    longint mask, half, ua, ub, sa, sb, v;
    n = 8 << sz;
    lanes = 8 >> sz;
    nb = n / 8;
    sat_ok = (sz < 2) && (md == 1 || md == 2);
    r = '0;
    s = '0;
    if (n == 64) begin
      r = (op != 0) ? a - b : a + b;
      return;
    end
    mask = (longint'(1) << n) - 1;
    half = longint'(1) << (n - 1);
    for (int l = 0; l < lanes; l++) begin
      ua = longint'(a >> (l * n)) & mask;
      ub = longint'(b >> (l * n)) & mask;
      sa = (ua >= half) ? ua - (mask + 1) : ua;
      sb = (ub >= half) ? ub - (mask + 1) : ub;
      cl = 1'b0;
      if (sat_ok && md == 1) begin
        v = (op != 0) ? sa - sb : sa + sb;
        if (v > half - 1) begin v = half - 1; cl = 1'b1; end
        else if (v < -half) begin v = -half; cl = 1'b1; end
      end else if (sat_ok && md == 2) begin
        v = (op != 0) ? ua - ub : ua + ub;
        if (v > mask) begin v = mask; cl = 1'b1; end
        else if (v < 0) begin v = 0; cl = 1'b1; end
      end else begin
        v = (op != 0) ? ua - ub : ua + ub;
      end
      v = v & mask;
      r = r | (64'(v) << (l * n));
      if (cl) s = s | 8'(((1 << nb) - 1) << (l * nb));
    end
  endfunction

  function automatic string tag_of(input int sz, input int md, input int op);
    if (sz < 2 && md == 1) return "R5";
    if (sz < 2 && md == 2) return "R6";
    if (md != 0) return "R7";
    return (op != 0) ? "R4" : "R3";
  endfunction

  task automatic run_one(input logic [63:0] a, input logic [63:0] b,
                         input int sz, input int md, input int op);
    logic [63:0] er;
    logic [7:0]  es;
    ref_op(a, b, sz, md, op, er, es);
    @(negedge clk);
    valid_i = 1'b1; a_i = a; b_i = b;
    size_i = 2'(sz); mode_i = 2'(md); op_i = 1'(op);
    @(negedge clk);
    check(tag_of(sz, md, op), res_o, er);
    check("R8", {56'd0, sat_o}, {56'd0, es});
  endtask

  function automatic logic [63:0] rep(input logic [63:0] v, input int sz);
    logic [63:0] r;
    int n;
    n = 8 << sz;
    r = '0;
    for (int l = 0; l < (8 >> sz); l++) r = r | (v << (l * n));
    return r;
  endfunction

  initial begin
    logic [63:0] cv [6];
    logic [63:0] held_r;
    logic [63:0] a, b;
    logic [63:0] msk, hf;
    int n;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {63'd0, valid_o}, 64'd0);
    check("R1", res_o, 64'd0);
    check("R1", {56'd0, sat_o}, 64'd0);
    rst_ni = 1'b1;

    // R2: latency and hold
    run_one(64'h0123_4567_89ab_cdef, 64'h1111_2222_3333_4444, 0, 0, 0);
    check("R2", {63'd0, valid_o}, 64'd1);
    held_r = res_o;
    valid_i = 1'b0; a_i = ~a_i; b_i = 64'h5555_5555_5555_5555;
    @(negedge clk);
    check("R2", {63'd0, valid_o}, 64'd0);
    check("R2", res_o, held_r);
    @(negedge clk);
    check("R2", res_o, held_r);

    // stepped grid sweep, distinct offsets per byte
    for (int sz = 0; sz < 4; sz++)
      for (int md = 0; md < 4; md++)
        for (int op = 0; op < 2; op++)
          for (int x = 0; x < 256; x += 5)
            for (int y = 0; y < 256; y += 7) begin
              for (int k = 0; k < 8; k++) begin
                a[k*8 +: 8] = 8'(x + k * 37);
                b[k*8 +: 8] = 8'(y + k * 91);
              end
              run_one(a, b, sz, md, op);
            end

    // lane-level extremes replicated across lanes
    for (int sz = 0; sz < 4; sz++) begin
      n = 8 << sz;
      msk = (n == 64) ? '1 : ((64'd1 << n) - 1);
      hf = 64'd1 << (n - 1);
      cv[0] = 64'd0; cv[1] = 64'd1; cv[2] = hf - 1;
      cv[3] = hf;    cv[4] = msk;   cv[5] = msk - 1;
      for (int md = 0; md < 4; md++)
        for (int op = 0; op < 2; op++)
          for (int j = 0; j < 6; j++)
            for (int k = 0; k < 6; k++)
              run_one(rep(cv[j], sz), rep(cv[k], sz), sz, md, op);
    end

    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule